// File: doc/BRIEF.md
# Bit-Reversed Sequence Step Counter

This block is a small synchronous counter whose state walks through the binary count with its bit order mirrored. With the default width of three, the visible value runs 0, 4, 2, 6, 1, 5, 3, 7 and then returns to 0. The output port is wired straight to the state flip-flops, so no decoding logic sits between the registers and the pins. A glitch-free registered value is therefore available the moment the state settles.

A single step input controls progress. While the step input is high, the counter moves one place on each rising clock edge. While it is low, the counter keeps its value. The next state comes from a toggle chain that starts at the top bit. The top bit flips on every advance. Each lower bit flips only when every bit above it is currently set.

A build-time mode selects a second form. In that form the step input is itself the register clock, so each rising edge of step advances the count once and the system clock is not used.

Top module: `revseq_counter`

## Requirements
- R1: Driving rst_ni low forces count_o to 0 at once, whatever step_i is doing. In the gated mode, release is synchronised by two clock stages, so with step_i held high the first advance happens on the third rising clk_i edge after rst_ni rises.
- R2: In the gated mode, a rising clk_i edge with step_i low leaves count_o unchanged.
- R3: Each advance moves count_o to the next value of the bit-mirrored binary count: 0, 4, 2, 6, 1, 5, 3, 7, 0 for WIDTH = 3. Bit b of the count equals bit WIDTH-1-b of the number of advances modulo 2^WIDTH.
- R4: On every advance the top bit, count_o[WIDTH-1], inverts.
- R5: On an advance, count_o[WIDTH-2] inverts exactly when count_o[WIDTH-1] was 1 before the edge.
- R6: On an advance, count_o[0] inverts exactly when all bits above it were 1 before the edge. For WIDTH = 3 this means bits 2 and 1 are both set.
- R7: An advance from the all-ones value gives 0 with no special case.
- R8: In the pulse mode (MODE = ADV_PULSE), every rising edge of step_i advances the count once, and clk_i edges have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; it is not used in the pulse mode |
| rst_ni | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Advance enable in the gated mode; register clock in the pulse mode |
| count_o | output | WIDTH | Counter state, driven straight from the flip-flops |

## Verification
The bench keeps an ordinary binary integer and mirrors its bits to get the expected value on every clock. Long enabled runs cross the 7-to-0 wrap several times. If the toggle chain took its carry from the wrong end, the output would follow the plain binary order. If the middle or bottom toggle term were wrong, the sequence would repeat early or skip codes such as 6 or 3.

Runs that mix hold cycles with advances would expose an enable that leaks. A reset asserted mid-run, with step held high through the release, would expose a release that is not delayed or a reset that loses priority to step. A second instance, built in the pulse mode, would show a counter that wrongly follows clk_i instead of step pulses.

// File: rtl/revseq_pkg.sv
package revseq_pkg;
  typedef enum logic {
    ADV_GATED = 1'b0,
    ADV_PULSE = 1'b1
  } adv_mode_e;

  localparam int unsigned DEF_WIDTH = 3;
  localparam int unsigned DEF_SYNC  = 2;
endpackage

// File: rtl/revseq_rst_sync.sv
module revseq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/revseq_toggle_chain.sv
module revseq_toggle_chain #(
  parameter int unsigned WIDTH = 3
) (
  input  logic [WIDTH-1:0] q_i,
  output logic [WIDTH-1:0] nxt_o
);
  logic [WIDTH-1:0] flip;

  // Carry runs from the top bit downwards: a bit flips when all above are set.
  always_comb begin
    logic carry;
    carry = 1'b1;
    for (int b = WIDTH - 1; b >= 0; b--) begin
      flip[b] = carry;
      carry   = carry & q_i[b];
    end
  end

  assign nxt_o = q_i ^ flip;
endmodule

// File: rtl/revseq_state_reg.sv
module revseq_state_reg
  import revseq_pkg::*;
#(
  parameter int unsigned WIDTH = 3,
  parameter adv_mode_e   MODE  = ADV_GATED
) (
  input  logic             clk_i,
  input  logic             arst_ni,
  input  logic             step_i,
  input  logic [WIDTH-1:0] nxt_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] state_q;

  if (MODE == ADV_PULSE) begin : g_pulse
    always_ff @(posedge step_i or negedge arst_ni) begin
      if (!arst_ni) state_q <= '0;
      else          state_q <= nxt_i;
    end
  end else begin : g_gated
    always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni)    state_q <= '0;
      else if (step_i) state_q <= nxt_i;
    end

    a_r1_reset_zero: assert property (@(posedge clk_i)
      !arst_ni |-> state_q == '0);
    a_r2_hold: assert property (@(posedge clk_i) disable iff (!arst_ni)
      !step_i |=> $stable(state_q));
    a_r4_top_flips: assert property (@(posedge clk_i) disable iff (!arst_ni)
      step_i |=> state_q[WIDTH-1] != $past(state_q[WIDTH-1]));
    a_r5_second_bit: assert property (@(posedge clk_i) disable iff (!arst_ni)
      step_i |=> state_q[WIDTH-2] == ($past(state_q[WIDTH-2]) ^ $past(state_q[WIDTH-1])));
    a_r6_low_bit: assert property (@(posedge clk_i) disable iff (!arst_ni)
      step_i |=> state_q[0] == ($past(state_q[0]) ^ (&$past(state_q[WIDTH-1:1]))));
    a_r7_wrap: assert property (@(posedge clk_i) disable iff (!arst_ni)
      (step_i && (&state_q)) |=> state_q == '0);
  end

  assign q_o = state_q;
endmodule

// File: rtl/revseq_counter.sv
module revseq_counter
  import revseq_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH,
  parameter int unsigned SYNC  = DEF_SYNC,
  parameter adv_mode_e   MODE  = ADV_GATED
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [WIDTH-1:0] count_o
);
  logic             run_n;
  logic [WIDTH-1:0] state;
  logic [WIDTH-1:0] state_nxt;

  if (MODE == ADV_PULSE) begin : g_raw_rst
    assign run_n = rst_ni;
  end else begin : g_sync_rst
    revseq_rst_sync #(.STAGES(SYNC)) i_rst_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .rst_no (run_n)
    );
  end

  revseq_toggle_chain #(.WIDTH(WIDTH)) i_chain (
    .q_i   (state),
    .nxt_o (state_nxt)
  );

  revseq_state_reg #(.WIDTH(WIDTH), .MODE(MODE)) i_state (
    .clk_i   (clk_i),
    .arst_ni (run_n),
    .step_i  (step_i),
    .nxt_i   (state_nxt),
    .q_o     (state)
  );

  assign count_o = state;
endmodule

// File: tb/test_revseq_counter.sv
`timescale 1ns/1ps
module test_revseq_counter;
  import revseq_pkg::*;
  localparam int W = 3;

  logic clk = 1'b0;
  logic rst_n, step;
  logic rst_p_n, pulse;
  logic [W-1:0] cnt, cnt_p;
  int checks = 0;
  int errors = 0;
  int ref_n  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  revseq_counter #(.WIDTH(W)) i_revseq_counter (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .count_o(cnt));

  revseq_counter #(.WIDTH(W), .MODE(ADV_PULSE)) i_revseq_counter_pulse (
    .clk_i(clk), .rst_ni(rst_p_n), .step_i(pulse), .count_o(cnt_p));

  function automatic logic [W-1:0] mirror(int v);
    logic [W-1:0] r;
    int m;
    m = v % (1 << W);
    for (int b = 0; b < W; b++) r[b] = m[W-1-b];
    return r;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycle(logic s, string tag);
    step = s;
    @(posedge clk);
    if (s) ref_n++;
    @(negedge clk);
    check(tag, cnt, mirror(ref_n));
  endtask

  initial begin
    #(20ns * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; step = 1'b1; rst_p_n = 1'b0; pulse = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset wins over step", cnt, '0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 sync stage 1", cnt, '0);
    @(posedge clk); @(negedge clk);
    check("R1 sync stage 2", cnt, '0);
    @(posedge clk); @(negedge clk);
    check("R1 first advance", cnt, 3'd4);
    ref_n = 1;
    // R3 R4 R5 R6 R7: long enabled run across several wraps
    for (int i = 0; i < 20; i++) cycle(1'b1, "R3 continuous");
    // R2: alternating hold and advance
    for (int i = 0; i < 16; i++) cycle(i[0], "R2 alternating");
    // R2 R3: irregular pattern
    for (int i = 0; i < 24; i++) cycle((i % 3) != 0, "R3 pattern");
    for (int i = 0; i < 4; i++) cycle(1'b0, "R2 long hold");
    // walk to all-ones, then wrap (R7)
    while (mirror(ref_n) != '1) cycle(1'b1, "R6 walk");
    cycle(1'b1, "R7 wrap to zero");
    check("R7 zero after wrap", cnt, '0);
    // R1: asynchronous reset mid-run with step held high
    cycle(1'b1, "R4 pre-reset");
    step = 1'b1;
    rst_n = 1'b0;
    #2;
    check("R1 async clear", cnt, '0);
    @(negedge clk);
    rst_n = 1'b1;
    ref_n = 0;
    step = 1'b0;
    cycle(1'b0, "R1 after release");
    cycle(1'b0, "R1 after release");
    for (int i = 0; i < 9; i++) cycle(1'b1, "R5 restart");

    // R8: pulse-mode instance
    @(negedge clk);
    check("R8 reset", cnt_p, '0);
    rst_p_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 clk ignored", cnt_p, '0);
    for (int n = 1; n <= 11; n++) begin
      #3 pulse = 1'b1;
      #3 pulse = 1'b0;
      #1 check("R8 pulse advance", cnt_p, mirror(n));
    end
    repeat (2) @(negedge clk);
    check("R8 clk ignored later", cnt_p, mirror(11));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule